// File: doc/BRIEF.md
# Grouped Power Rail Sequencer

This block brings a board's supply rails up in seven ordered power groups. Group 0 is the master enable input. Groups 1 to 5 drive rail enable outputs: 3, 7, 6, 5 and 1 rails respectively. Group 6 drives the module power-good output and releases the system resets. When the master enable rises, the sequencer walks through the groups in order. For each group it asserts the group's enables and waits until every monitored power-good input of that group is high. It then waits a settle delay before enabling the next group.

Some rails have no power-good input. Three rails in group 2 and four in group 4 are unmonitored, and they count as good as soon as they are enabled. Each group has a qualification window, 200 ms by default. A monitored power-good input that has not come up within that window is a fault. A monitored input of an already qualified group that falls is also a fault. On a fault the block drops every enable at once and pulls its active-low fault flag low. It holds that state until the master enable is removed.

Every input, master enable included, passes through a two-flop synchroniser. It then passes through a stable-level debounce counted in 1 µs prescaler ticks. The tick is derived from the `CLK_HZ` parameter. The settle delay is 10 µs before groups 1 to 5 and 0 µs before group 6.

Top module: `pwr_grp_seq`

## Requirements
- R1: Groups are enabled strictly in numeric order, one at a time, so the enabled set is always groups 0..k. `rail_en_o` packs the rail enables as follows: [2:0] group 1, [9:3] group 2, [15:10] group 3, [20:16] group 4, [21] group 5. `som_pg_o` is group 6.
- R2: After a group qualifies, the next group of 1 to 5 is enabled SETTLE_US microsecond ticks later. Group 6 is enabled LAST_SETTLE_US ticks later (default 0). One tick lasts CLK_HZ/1e6 clock cycles.
- R3: If a newly enabled group's monitored power-good inputs are not all high within QUAL_US ticks of its enable, a fault is raised.
- R4: On a fault, all rail enables and `som_pg_o` go low in the same cycle, and `seq_fault_n_o` goes low.
- R5: The fault stays latched while the master enable is high, even if power-good returns. Removing the master enable clears it, and `seq_fault_n_o` returns to 1.
- R6: `grp_stat_o` bit n is 1 when group n is enabled, and bit 7 is always 0. The vector reads 0x00 after reset and 0x7F when fully powered.
- R7: `pg_stat_o` bit 0 is the debounced master enable and bit 1+i is debounced `pg_i[i]`. `pg_i` is ordered [2:0] group 1, [6:3] group 2, [12:7] group 3, [13] group 4, [14] group 5. The vector reads 0xFFFF when healthy.
- R8: `mr_n_o` and `sys_rst_n_o` stay low until group 6 is enabled. They go high only then, and go low again when group 6 drops.
- R9: When the debounced master enable goes low, all enables drop on the next clock and the sequencer returns to idle.
- R10: An input level must persist for DB_TICKS ticks before it is taken. Shorter pulses on the master enable or on power-good inputs have no effect.
- R11: Progress through a group depends only on its monitored inputs. Unmonitored rails count good as soon as they are enabled.
- R12: If a monitored power-good input of an already qualified group falls, a fault is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| master_en_i | input | 1 | Master enable (group 0) |
| pg_i | input | 15 | Monitored power-good inputs, in group order |
| rail_en_o | output | 22 | Rail enables of groups 1 to 5 |
| som_pg_o | output | 1 | Module power-good (group 6) |
| grp_stat_o | output | 8 | Group enable status |
| pg_stat_o | output | 16 | Debounced power-good status |
| seq_fault_n_o | output | 1 | Fault flag, active low |
| mr_n_o | output | 1 | Manual reset, active low |
| sys_rst_n_o | output | 1 | System reset, active low |

## Verification
An input change reaches `pg_stat_o` after two synchroniser cycles plus DB_TICKS ticks, rounded to the tick phase. A change that completes a group's qualification enables the next group after a further SETTLE_US ticks plus two register cycles. A timeout fault appears between QUAL_US-1 and QUAL_US ticks after the group's enable. Because the tick phase is free-running, each timed check measures the distance between recorded edge cycles and compares it against a window. The lower bound of that window is one tick short of the nominal delay, and the upper bound is the nominal delay plus a few register stages. Level checks are taken only after the longest such window has passed.

// File: rtl/pwr_grp_seq.sv
module pwr_grp_seq #(
  parameter int CLK_HZ         = 100_000_000,
  parameter int SETTLE_US      = 10,
  parameter int LAST_SETTLE_US = 0,
  parameter int QUAL_US        = 200_000,
  parameter int DB_TICKS       = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        master_en_i,
  input  logic [14:0] pg_i,
  output logic [21:0] rail_en_o,
  output logic        som_pg_o,
  output logic [7:0]  grp_stat_o,
  output logic [15:0] pg_stat_o,
  output logic        seq_fault_n_o,
  output logic        mr_n_o,
  output logic        sys_rst_n_o
);

  localparam int PRE  = (CLK_HZ / 1_000_000 < 1) ? 1 : CLK_HZ / 1_000_000;
  localparam int PW   = (PRE > 1) ? $clog2(PRE) : 1;
  localparam int TMAX = QUAL_US + SETTLE_US + LAST_SETTLE_US + 2;
  localparam int TW   = $clog2(TMAX);
  localparam int DBW  = $clog2(DB_TICKS + 1);
  localparam int NIN  = 16;

  typedef enum logic [2:0] {S_OFF, S_SETTLE, S_QUAL, S_ON, S_FAULT} st_e;

  function automatic logic [15:0] grp_mask(input logic [2:0] g);
    case (g)
      3'd0:    grp_mask = 16'h0001;
      3'd1:    grp_mask = 16'h000E;
      3'd2:    grp_mask = 16'h00F0;
      3'd3:    grp_mask = 16'h3F00;
      3'd4:    grp_mask = 16'h4000;
      3'd5:    grp_mask = 16'h8000;
      default: grp_mask = 16'h0000;
    endcase
  endfunction

  // microsecond time base
  logic [PW-1:0] pre_q;
  logic          tick;
  assign tick = (pre_q == PW'(PRE - 1));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)    pre_q <= '0;
    else if (tick) pre_q <= '0;
    else           pre_q <= pre_q + 1'b1;

  // synchroniser and debounce
  logic [NIN-1:0] raw, s1, s2, stab;
  assign raw = {pg_i, master_en_i};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1 <= '0;
      s2 <= '0;
    end else begin
      s1 <= raw;
      s2 <= s1;
    end

  for (genvar i = 0; i < NIN; i++) begin : g_db
    logic [DBW-1:0] cnt;
    logic           lvl;
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        cnt <= '0;
        lvl <= 1'b0;
      end else if (s2[i] == lvl) begin
        cnt <= '0;
      end else if (tick) begin
        if (cnt == DBW'(DB_TICKS - 1)) begin
          cnt <= '0;
          lvl <= s2[i];
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    assign stab[i] = lvl;
  end

  // sequencer
  st_e           st;
  logic [2:0]    grp_q;
  logic [6:0]    en_q;
  logic [TW-1:0] tmr;
  logic [15:0]   cur_mask, held;
  logic          grp_ok, held_ok, settle_done;

  always_comb begin
    cur_mask = grp_mask(grp_q);
    held     = '0;
    for (int g = 1; g <= 5; g++)
      if (3'(g) < grp_q || (3'(g) == grp_q && st != S_QUAL))
        held = held | grp_mask(3'(g));
  end

  assign grp_ok      = (stab & cur_mask) == cur_mask;
  assign held_ok     = (stab & held) == held;
  assign settle_done = tmr >= ((grp_q == 3'd5) ? TW'(LAST_SETTLE_US) : TW'(SETTLE_US));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_OFF; grp_q <= '0; en_q <= '0; tmr <= '0;
    end else if (!stab[0]) begin
      st <= S_OFF; grp_q <= '0; en_q <= '0; tmr <= '0;
    end else begin
      case (st)
        S_OFF: begin
          st <= S_SETTLE; grp_q <= '0; en_q <= 7'd1; tmr <= '0;
        end
        S_SETTLE:
          if (!held_ok) begin
            st <= S_FAULT; grp_q <= '0; en_q <= '0; tmr <= '0;
          end else if (settle_done) begin
            grp_q <= grp_q + 3'd1;
            en_q  <= {en_q[5:0], 1'b1};
            tmr   <= '0;
            st    <= (grp_q == 3'd5) ? S_ON : S_QUAL;
          end else if (tick) begin
            tmr <= tmr + 1'b1;
          end
        S_QUAL:
          if (!held_ok) begin
            st <= S_FAULT; grp_q <= '0; en_q <= '0; tmr <= '0;
          end else if (grp_ok) begin
            st <= S_SETTLE; tmr <= '0;
          end else if (tmr >= TW'(QUAL_US)) begin
            st <= S_FAULT; grp_q <= '0; en_q <= '0; tmr <= '0;
          end else if (tick) begin
            tmr <= tmr + 1'b1;
          end
        S_ON:
          if (!held_ok) begin
            st <= S_FAULT; grp_q <= '0; en_q <= '0; tmr <= '0;
          end
        default: ;
      endcase
    end

  assign rail_en_o     = {{1{en_q[5]}}, {5{en_q[4]}}, {6{en_q[3]}}, {7{en_q[2]}}, {3{en_q[1]}}};
  assign som_pg_o      = en_q[6];
  assign grp_stat_o    = {1'b0, en_q};
  assign pg_stat_o     = stab;
  assign seq_fault_n_o = (st != S_FAULT);
  assign mr_n_o        = en_q[6];
  assign sys_rst_n_o   = en_q[6];

  a_r1_thermo: assert property (@(posedge clk) disable iff (!rst_n)
    ((grp_stat_o[6:0] + 7'd1) & grp_stat_o[6:0]) == 7'd0);

  a_r1_step: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q != 7'd0 && en_q != $past(en_q)) |-> en_q == {$past(en_q[5:0]), 1'b1});

  a_r3_window: assert property (@(posedge clk) disable iff (!rst_n)
    !(st == S_QUAL && tmr > TW'(QUAL_US)));

  a_r4_fault_off: assert property (@(posedge clk) disable iff (!rst_n)
    !seq_fault_n_o |-> (rail_en_o == 22'd0 && !som_pg_o));

  a_r5_latch: assert property (@(posedge clk) disable iff (!rst_n)
    (!seq_fault_n_o && stab[0]) |=> !seq_fault_n_o);

  a_r8_rst_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mr_n_o || sys_rst_n_o) |-> (rail_en_o == {22{1'b1}} && grp_stat_o == 8'h7F));

  a_r9_master_off: assert property (@(posedge clk) disable iff (!rst_n)
    !stab[0] |=> grp_stat_o == 8'h00);

  a_r10_tick_only: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(pg_stat_o));

endmodule

// File: tb/pwr_grp_seq_tb_top.sv
module pwr_grp_seq_tb_top;

  localparam int CLK_HZ = 4_000_000;
  localparam int PRE    = 4;
  localparam int SET_US = 10;
  localparam int QUAL   = 300;
  localparam int DB     = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        master_en_i = 1'b0;
  logic [14:0] pg_i = '0;
  logic [21:0] rail_en_o;
  logic        som_pg_o;
  logic [7:0]  grp_stat_o;
  logic [15:0] pg_stat_o;
  logic        seq_fault_n_o, mr_n_o, sys_rst_n_o;

  always #2.5 clk = ~clk;

  pwr_grp_seq #(.CLK_HZ(CLK_HZ), .SETTLE_US(SET_US), .LAST_SETTLE_US(0),
                .QUAL_US(QUAL), .DB_TICKS(DB)) dut_i (
    .clk(clk), .rst_n(rst_n), .master_en_i(master_en_i), .pg_i(pg_i),
    .rail_en_o(rail_en_o), .som_pg_o(som_pg_o), .grp_stat_o(grp_stat_o),
    .pg_stat_o(pg_stat_o), .seq_fault_n_o(seq_fault_n_o),
    .mr_n_o(mr_n_o), .sys_rst_n_o(sys_rst_n_o));

  int n_chk = 0, n_fail = 0;
  int cyc = 0;
  int rise [7];
  int dly [15];
  int pcnt [15];
  logic [14:0] hold_low = '0;
  logic [7:0]  prev = '0;
  int order_bad = 0, rst_bad = 0, rail_bad = 0;
  bit done = 0;

  function automatic int grp_of(input int i);
    if (i < 3) return 1;
    if (i < 7) return 2;
    if (i < 13) return 3;
    if (i == 13) return 4;
    return 5;
  endfunction

  function automatic logic [21:0] exp_rails(input logic [7:0] s);
    return {{1{s[5]}}, {5{s[4]}}, {6{s[3]}}, {7{s[2]}}, {3{s[1]}}};
  endfunction

  function automatic int max_dly(input int g);
    int m = 0;
    for (int i = 0; i < 15; i++)
      if (grp_of(i) == g && dly[i] > m) m = dly[i];
    return m;
  endfunction

  function automatic int gap_lo(input int g);
    int s = (g == 6) ? 0 : SET_US;
    int m = max_dly(g - 1);
    return ((m > 0) ? m - 1 : 0) + (DB + s - 2) * PRE;
  endfunction

  function automatic int gap_hi(input int g);
    int s = (g == 6) ? 0 : SET_US;
    return max_dly(g - 1) + (DB + s) * PRE + 8;
  endfunction

  always @(posedge clk) cyc <= cyc + 1;

  // rail model and edge recorder
  always @(negedge clk) begin
    for (int i = 0; i < 15; i++) begin
      if (grp_stat_o[grp_of(i)]) begin
        pcnt[i] = pcnt[i] + 1;
        pg_i[i] = (pcnt[i] >= dly[i]) && !hold_low[i];
      end else begin
        pcnt[i] = 0;
        pg_i[i] = 1'b0;
      end
    end
    for (int g = 0; g < 7; g++)
      if (grp_stat_o[g] && !prev[g]) rise[g] = cyc;
    prev = grp_stat_o;
    if (rst_n) begin
      if (((grp_stat_o[6:0] + 7'd1) & grp_stat_o[6:0]) != 0 || grp_stat_o[7]) order_bad++;
      if ((mr_n_o || sys_rst_n_o) && !grp_stat_o[6]) rst_bad++;
      if (!mr_n_o && grp_stat_o[6]) rst_bad++;
      if (rail_en_o != exp_rails(grp_stat_o) || som_pg_o != grp_stat_o[6]) rail_bad++;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", tag, act, act, exp, exp);
    end
  endtask

  task automatic wcyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic power_up();
    int n = 0;
    master_en_i = 1'b1;
    while (grp_stat_o != 8'h7F && seq_fault_n_o && n < 20000) begin
      wcyc(1);
      n++;
    end
  endtask

  task automatic power_down();
    master_en_i = 1'b0;
    wcyc((DB + 1) * PRE + 6);
    chk(grp_stat_o == 8'h00, "R9 status after master off", grp_stat_o, 0);
    chk(rail_en_o == 22'd0 && !som_pg_o, "R9 rails off after master off", rail_en_o, 0);
    chk(!mr_n_o && !sys_rst_n_o, "R8 resets reasserted", {mr_n_o, sys_rst_n_o}, 0);
    wcyc((DB + 1) * PRE + 6);
    chk(pg_stat_o == 16'h0000, "R7 pg status cleared", pg_stat_o, 0);
  endtask

  task automatic rand_trial();
    for (int i = 0; i < 15; i++) dly[i] = $urandom_range(0, 150);
    power_up();
    chk(grp_stat_o == 8'h7F, "R6 full status", grp_stat_o, 'h7F);
    chk(seq_fault_n_o == 1'b1, "R3 no fault when all good in time", seq_fault_n_o, 1);
    chk(mr_n_o && sys_rst_n_o, "R8 resets released", {mr_n_o, sys_rst_n_o}, 3);
    wcyc((DB + 1) * PRE + 6);
    chk(pg_stat_o == 16'hFFFF, "R7 healthy pg status", pg_stat_o, 'hFFFF);
    chk(rise[1] - rise[0] >= (SET_US - 1) * PRE && rise[1] - rise[0] <= SET_US * PRE + 2,
        "R2 settle before group 1", rise[1] - rise[0], SET_US * PRE);
    for (int g = 2; g <= 6; g++) begin
      int gap = rise[g] - rise[g - 1];
      chk(gap >= gap_lo(g) && gap <= gap_hi(g),
          (g == 3 || g == 5) ? "R11 gap after group with unmonitored rails" : "R2 group gap",
          gap, gap_lo(g));
    end
    power_down();
  endtask

  initial begin
    for (int i = 0; i < 15; i++) begin dly[i] = 0; pcnt[i] = 0; end
    for (int g = 0; g < 7; g++) rise[g] = 0;
    void'($urandom(32'd1234));
    wcyc(5);
    rst_n = 1'b1;
    wcyc(3);
    chk(grp_stat_o == 8'h00, "R6 reset status", grp_stat_o, 0);
    chk(rail_en_o == 22'd0 && !som_pg_o, "R1 rails off at reset", rail_en_o, 0);
    chk(!mr_n_o && !sys_rst_n_o, "R8 resets held at reset", {mr_n_o, sys_rst_n_o}, 0);
    chk(seq_fault_n_o == 1'b1, "R5 no fault at reset", seq_fault_n_o, 1);
    chk(pg_stat_o == 16'h0000, "R7 pg status at reset", pg_stat_o, 0);

    // short master pulse is ignored
    master_en_i = 1'b1;
    wcyc(5);
    master_en_i = 1'b0;
    wcyc(40);
    chk(grp_stat_o == 8'h00 && pg_stat_o == 16'h0, "R10 master glitch ignored", grp_stat_o, 0);

    for (int t = 0; t < 4; t++) rand_trial();

    // qualification timeout in group 3
    for (int i = 0; i < 15; i++) dly[i] = 5;
    hold_low = 15'h0100;
    master_en_i = 1'b1;
    begin
      int n = 0;
      while (!grp_stat_o[3] && n < 5000) begin wcyc(1); n++; end
    end
    wcyc(100);
    chk(pg_stat_o == 16'h3DFF, "R7 bit position of held input", pg_stat_o, 'h3DFF);
    begin
      int n = 0;
      while (seq_fault_n_o && n < 5000) begin wcyc(1); n++; end
    end
    chk(cyc - 1 - rise[3] >= (QUAL - 1) * PRE && cyc - 1 - rise[3] <= QUAL * PRE + 3,
        "R3 timeout delay", cyc - 1 - rise[3], QUAL * PRE);
    chk(grp_stat_o == 8'h00 && rail_en_o == 22'd0 && !seq_fault_n_o,
        "R4 all off on fault", rail_en_o, 0);
    wcyc(100);
    hold_low = '0;
    wcyc(100);
    chk(!seq_fault_n_o && grp_stat_o == 8'h00, "R5 fault latched", seq_fault_n_o, 0);
    master_en_i = 1'b0;
    wcyc((DB + 1) * PRE + 6);
    chk(seq_fault_n_o == 1'b1, "R5 fault cleared by master off", seq_fault_n_o, 1);
    wcyc(40);

    // short power-good dip after full power is ignored
    for (int i = 0; i < 15; i++) dly[i] = $urandom_range(0, 40);
    power_up();
    wcyc(20);
    hold_low[3] = 1'b1;
    wcyc((DB - 1) * PRE - 3);
    hold_low[3] = 1'b0;
    wcyc((DB + 2) * PRE + 10);
    chk(seq_fault_n_o && grp_stat_o == 8'h7F, "R10 pg glitch ignored", grp_stat_o, 'h7F);
    chk(pg_stat_o == 16'hFFFF, "R10 pg status unchanged by glitch", pg_stat_o, 'hFFFF);

    // lost power-good of a qualified group
    hold_low[14] = 1'b1;
    wcyc((DB + 1) * PRE + 6);
    chk(!seq_fault_n_o, "R12 fault on lost power-good", seq_fault_n_o, 0);
    chk(grp_stat_o == 8'h00 && !mr_n_o, "R12 rails dropped on lost power-good", grp_stat_o, 0);
    hold_low = '0;
    power_down();

    chk(order_bad == 0, "R1 status always contiguous", order_bad, 0);
    chk(rail_bad == 0, "R1 rail packing follows status", rail_bad, 0);
    chk(rst_bad == 0, "R8 resets track group 6", rst_bad, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule